// File: doc/BRIEF.md
# Synchronous Marker-Bit Shift Receiver

This block receives one byte over a two-wire synchronous link in which it is the clock master. It drives a shift clock to an external device and reads a data pin once per machine cycle. A free-running sequencer divides the system clock into machine cycles of six states with two phases each, which is twelve system clocks. Sampling, shifting and clock edges all happen at fixed phases inside each machine cycle.

Software starts a reception with a control write that sets the enable field and clears the done flag. The receive shift register is then loaded with a single zero in its rightmost cell and ones everywhere else. Data enters from the right. The end of the byte is detected when that zero reaches the leftmost cell, so the block has no bit counter. One more shift follows. Two machine cycles later the byte is copied to the output register and the done flag rises.

Top module: `sync_marker_rx`

## Requirements
- R1: Reset (synchronous, active high) drives `sclk` high, `rx_done` low and `rx_byte` to zero. On the first clock edge with reset low, the sequencer is at state 1 phase 1. Every later edge advances it by one step, so a machine cycle is 12 clocks and step k of the cycle is state (k/2)+1, phase (k%2)+1.
- R2: `sclk` stays high while no reception is active. A control write with `wr_rx_en`=0 starts nothing.
- R3: While a reception is active, `sclk` falls on the state 3 phase 1 edge (step 4) and rises on the state 6 phase 1 edge (step 10).
- R4: `rx_din` is sampled only on the state 5 phase 2 edge (step 9). The shift that follows at state 6 phase 2 moves that sample in from the right. The first sampled bit ends up in `rx_byte[7]` and the eighth in `rx_byte[0]`.
- R5: A control write with `wr_rx_en`=1 and `wr_done`=0 clears `rx_done` at once. When no reception is active, the same write starts one on the first state 1 phase 1 edge after the write.
- R6: `rx_done` rises and `rx_byte` is loaded on the state 1 phase 1 edge that begins the tenth machine cycle after the write, which is 108 clocks after reception starts. Neither happens earlier.
- R7: Completion is detected by the marker zero and does not depend on the data value, including all-zero and all-one bytes.
- R8: A control write that arrives during an active reception neither restarts it nor moves its completion.
- R9: `rx_byte` holds its value between completions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_ctrl | input | 1 | One-clock control write strobe |
| wr_rx_en | input | 1 | Enable field of the control write |
| wr_done | input | 1 | Done-flag value written by the control write |
| rx_din | input | 1 | Serial data pin |
| sclk | output | 1 | Shift clock to the external device |
| rx_byte | output | 8 | Last received byte |
| rx_done | output | 1 | Receive-done flag |

## Verification
The bench starts receptions at write positions of 0, 7 and 11 within the machine cycle. A design that started on the wrong state 1 phase 1 edge would raise its clock fall and its done flag twelve clocks early or late. The data pin holds the inverted bit on the edges on either side of the sampling edge, so sampling on the wrong phase shows up as a corrupted byte. The bytes 0x00 and 0xFF test the marker logic: a detector that mistook incoming zeros for the marker would finish early. A write that restarted a reception already in flight would postpone `rx_done` beyond the expected edge. The bench also checks that a disabled write leaves `sclk` high and `rx_byte` unchanged.

// File: rtl/smr_pkg.sv
package smr_pkg;

    typedef struct packed {
        logic s1p1;
        logic s3p1;
        logic s5p2;
        logic s6p1;
        logic s6p2;
    } smr_strb_t;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_ARM    = 3'd1,
        ST_SHIFT  = 3'd2,
        ST_FLUSH1 = 3'd3,
        ST_FLUSH2 = 3'd4
    } smr_state_t;

    // step index within a machine cycle, states and phases counted from 1
    function automatic int step_idx(input int st, input int ph, input int phases);
        return (st - 1) * phases + (ph - 1);
    endfunction

endpackage

// File: rtl/smr_mcyc_seq.sv
module smr_mcyc_seq
    import smr_pkg::*;
#(
    parameter int STATES = 6,
    parameter int PHASES = 2
) (
    input  logic      clk,
    input  logic      rst,
    output smr_strb_t strb
);
    localparam int NSTEP  = STATES * PHASES;
    localparam int STEP_W = $clog2(NSTEP);

    logic [STEP_W-1:0] step_q;

    always_ff @(posedge clk) begin
        if (rst)
            step_q <= '0;
        else if (step_q == STEP_W'(NSTEP - 1))
            step_q <= '0;
        else
            step_q <= step_q + 1'b1;
    end

    always_comb begin
        strb.s1p1 = (step_q == STEP_W'(step_idx(1, 1, PHASES)));
        strb.s3p1 = (step_q == STEP_W'(step_idx(3, 1, PHASES)));
        strb.s5p2 = (step_q == STEP_W'(step_idx(5, 2, PHASES)));
        strb.s6p1 = (step_q == STEP_W'(step_idx(6, 1, PHASES)));
        strb.s6p2 = (step_q == STEP_W'(step_idx(6, 2, PHASES)));
    end

    p_strobe_onehot_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({strb.s1p1, strb.s3p1, strb.s5p2, strb.s6p1, strb.s6p2}));

    p_cycle_start_r1: assert property (@(posedge clk) disable iff (rst)
        strb.s6p2 |=> strb.s1p1);

endmodule

// File: rtl/smr_shifter.sv
module smr_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              shift_en,
    input  logic              s5p2,
    input  logic              s6p2,
    input  logic              din,
    output logic [DATA_W-1:0] sreg,
    output logic              last
);
    localparam logic [DATA_W-1:0] PRELOAD = {{(DATA_W-1){1'b1}}, 1'b0};

    logic samp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sreg   <= '1;
            samp_q <= 1'b0;
        end else begin
            if (shift_en && s5p2)
                samp_q <= din;
            if (load)
                sreg <= PRELOAD;
            else if (shift_en && s6p2)
                sreg <= {sreg[DATA_W-2:0], samp_q};
        end
    end

    // the marker has reached the leftmost cell: the next shift is the final one
    assign last = ~sreg[DATA_W-1];

    p_shift_phase_r4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sreg) && !$past(load)) |-> $past(s6p2));

endmodule

// File: rtl/smr_ctrl.sv
module smr_ctrl
    import smr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              s1p1,
    input  logic              s3p1,
    input  logic              s6p1,
    input  logic              s6p2,
    input  logic              wr_ctrl,
    input  logic              wr_rx_en,
    input  logic              wr_done,
    input  logic              last,
    input  logic [DATA_W-1:0] sreg,
    output logic              load,
    output logic              shift_en,
    output logic              sclk,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    smr_state_t st_q, st_nxt;
    logic       start_req;
    logic       active;
    logic       finish;

    assign start_req = wr_ctrl && wr_rx_en && !wr_done;
    assign active    = (st_q == ST_SHIFT) || (st_q == ST_FLUSH1) || (st_q == ST_FLUSH2);
    assign load      = (st_q == ST_ARM) && s1p1;
    assign shift_en  = (st_q == ST_SHIFT);
    assign finish    = (st_q == ST_FLUSH2) && s1p1;

    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_IDLE:   if (start_req)     st_nxt = ST_ARM;
            ST_ARM:    if (s1p1)          st_nxt = ST_SHIFT;
            ST_SHIFT:  if (s6p2 && last)  st_nxt = ST_FLUSH1;
            ST_FLUSH1: if (s1p1)          st_nxt = ST_FLUSH2;
            ST_FLUSH2: if (s1p1)          st_nxt = ST_IDLE;
            default:                      st_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            sclk    <= 1'b1;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            st_q <= st_nxt;
            if (!active || s6p1)
                sclk <= 1'b1;
            else if (s3p1)
                sclk <= 1'b0;
            if (finish) begin
                done    <= 1'b1;
                rx_byte <= sreg;
            end else if (wr_ctrl) begin
                done <= wr_done;
            end
        end
    end

    p_sclk_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !active |-> sclk);

    p_sclk_fall_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk) |-> $past(s3p1));

    p_sclk_rise_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sclk) |-> $past(s6p1));

    p_done_edge_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> ($past(s1p1) || $past(wr_ctrl)));

    p_byte_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> (done && $past(s1p1)));

endmodule

// File: rtl/sync_marker_rx.sv
module sync_marker_rx
    import smr_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STATES = 6,
    parameter int PHASES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_rx_en,
    input  logic              wr_done,
    input  logic              rx_din,
    output logic              sclk,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_done
);
    smr_strb_t         strb;
    logic              load;
    logic              shift_en;
    logic              last;
    logic [DATA_W-1:0] sreg;

    smr_mcyc_seq #(.STATES(STATES), .PHASES(PHASES)) u_seq (
        .clk  (clk),
        .rst  (rst),
        .strb (strb)
    );

    smr_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .shift_en (shift_en),
        .s5p2     (strb.s5p2),
        .s6p2     (strb.s6p2),
        .din      (rx_din),
        .sreg     (sreg),
        .last     (last)
    );

    smr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .s1p1     (strb.s1p1),
        .s3p1     (strb.s3p1),
        .s6p1     (strb.s6p1),
        .s6p2     (strb.s6p2),
        .wr_ctrl  (wr_ctrl),
        .wr_rx_en (wr_rx_en),
        .wr_done  (wr_done),
        .last     (last),
        .sreg     (sreg),
        .load     (load),
        .shift_en (shift_en),
        .sclk     (sclk),
        .done     (rx_done),
        .rx_byte  (rx_byte)
    );

endmodule

// File: tb/tb_sync_marker_rx.sv
`timescale 1ns/1ps
module tb_sync_marker_rx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_ctrl = 1'b0;
    logic       wr_rx_en = 1'b0;
    logic       wr_done = 1'b0;
    logic       rx_din = 1'b1;
    logic       sclk;
    logic [7:0] rx_byte;
    logic       rx_done;

    int checks = 0;
    int errors = 0;
    int ecnt   = 0;

    sync_marker_rx dut (
        .clk(clk), .rst(rst), .wr_ctrl(wr_ctrl), .wr_rx_en(wr_rx_en),
        .wr_done(wr_done), .rx_din(rx_din), .sclk(sclk),
        .rx_byte(rx_byte), .rx_done(rx_done)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // number of rising edges seen with reset low; edge i runs at sequencer step i % 12
    always @(posedge clk) if (!rst) ecnt <= ecnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic goto_edge(input int e);
        while (ecnt < e) @(negedge clk);
    endtask

    task automatic ctrl_write(input bit en, input bit dn);
        wr_ctrl = 1'b1; wr_rx_en = en; wr_done = dn;
        @(negedge clk);
        wr_ctrl = 1'b0; wr_rx_en = 1'b0; wr_done = 1'b0;
    endtask

    task automatic test_reset();
        check(sclk == 1'b1, "R1", "sclk after reset", sclk, 1);
        check(rx_done == 1'b0, "R1", "done after reset", rx_done, 0);
        check(rx_byte == 8'h00, "R1", "byte after reset", rx_byte, 0);
    endtask

    // one complete reception; phase picks where in the machine cycle the write lands
    task automatic test_frame(input logic [7:0] b, input int phase, input bit rewrite,
                              input string req);
        int w;
        int l;
        while ((ecnt % 12) != phase) @(negedge clk);
        w = ecnt;
        ctrl_write(1'b1, 1'b0);
        check(rx_done == 1'b0, "R5", "done cleared by write", rx_done, 0);
        l = (w / 12 + 1) * 12;
        for (int j = 0; j < 8; j++) begin
            goto_edge(l + 12*j + 4);
            if (j == 0)
                check(sclk == 1'b1, "R5", "sclk before first fall", sclk, 1);
            goto_edge(l + 12*j + 5);
            check(sclk == 1'b0, (j == 0) ? "R5" : "R3", "sclk low after step 4", sclk, 0);
            goto_edge(l + 12*j + 8);
            rx_din = ~b[7-j];
            goto_edge(l + 12*j + 9);
            rx_din = b[7-j];
            goto_edge(l + 12*j + 10);
            rx_din = ~b[7-j];
            goto_edge(l + 12*j + 11);
            check(sclk == 1'b1, "R3", "sclk high after step 10", sclk, 1);
            if (rewrite && j == 3) ctrl_write(1'b1, 1'b0);
        end
        goto_edge(l + 108);
        check(rx_done == 1'b0, "R6", "done not early", rx_done, 0);
        goto_edge(l + 109);
        check(rx_done == 1'b1, rewrite ? "R8" : "R6", "done at cycle ten", rx_done, 1);
        check(rx_byte == b, req, "received byte", rx_byte, b);
        goto_edge(l + 115);
        check(sclk == 1'b1, "R2", "sclk idle after frame", sclk, 1);
    endtask

    task automatic test_disabled(input logic [7:0] held);
        int w;
        bit low_seen;
        ctrl_write(1'b0, 1'b0);
        w = ecnt;
        low_seen = 1'b0;
        while (ecnt < w + 130) begin
            rx_din = ecnt[0];
            if (sclk != 1'b1) low_seen = 1'b1;
            @(negedge clk);
        end
        check(!low_seen, "R2", "sclk never low when disabled", low_seen, 0);
        check(rx_done == 1'b0, "R2", "done stays low when disabled", rx_done, 0);
        check(rx_byte == held, "R9", "byte held", rx_byte, held);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        test_reset();
        test_frame(8'hA5, 0, 1'b0, "R4");
        test_frame(8'h3C, 7, 1'b0, "R4");
        test_frame(8'h00, 11, 1'b0, "R7");
        test_frame(8'hFF, 3, 1'b0, "R7");
        test_disabled(8'hFF);
        test_frame(8'h96, 5, 1'b1, "R8");
        test_frame(8'h01, 0, 1'b0, "R4");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule